// File: doc/BRIEF.md
# Shunt Reading Window Monitor

This block checks every finished shunt-current conversion against a window whose two edges are stored in a single 16-bit limit register. The high byte of that register holds the ceiling and the low byte holds the floor. Each byte is a two's-complement value. A step of one count in a limit equals 256 counts of the shunt reading. The block scales both edges up and compares them with the signed reading on the cycle the conversion-done strobe is high. No comparison happens on any other cycle.

A reading above the ceiling sets a sticky over flag. A reading below the floor sets a sticky under flag. Both flags stay set until a clear strobe arrives. An interrupt output follows the flags, gated by an enable input. Host logic loads the limit register through a write strobe and can read the stored word back at any time. After reset the register holds the widest possible window.

Top module: `shunt_window_mon`

## Requirements
- R1: While reset is asserted and after it is released, the limit register reads 0x7F80, and the over flag, the under flag and the interrupt are all 0.
- R2: When `lim_we` is 1 at a clock edge, `lim_rdata` shows `lim_wdata` from the next cycle on. When `lim_we` is 0, the stored word is unchanged.
- R3: The ceiling is bits 15:8 and the floor is bits 7:0. Each is a signed 8-bit value, with bits 15 and 7 weighted -128. Each is multiplied by 256 and compared with the signed 16-bit `shunt_code`.
- R4: If `conv_done` is 1 and `shunt_code` is strictly greater than ceiling×256, `over_flag` is 1 in the next cycle. A reading equal to the edge does not set it.
- R5: If `conv_done` is 1 and `shunt_code` is strictly less than floor×256, `under_flag` is 1 in the next cycle. A reading equal to the edge does not set it, so a floor of -128 can never trip.
- R6: A `shunt_code` presented while `conv_done` is 0 has no effect on either flag.
- R7: Flags stay set across later in-window conversions. A `flag_clr` pulse with no crossing in the same cycle clears both flags in the next cycle.
- R8: If a crossing is detected in the same cycle as `flag_clr`, the crossed flag is 1 in the next cycle.
- R9: `irq` equals `irq_en` AND (`over_flag` OR `under_flag`), and it follows `irq_en` within the same cycle.
- R10: A conversion in the same cycle as a limit write is judged against the limits stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_done | input | 1 | One-cycle strobe that marks a valid `shunt_code` |
| shunt_code | input | 16 | Signed shunt reading |
| lim_we | input | 1 | Write strobe for the limit register |
| lim_wdata | input | 16 | New limit word: ceiling in the high byte, floor in the low byte |
| lim_rdata | output | 16 | Stored limit word |
| flag_clr | input | 1 | Clears both flags |
| irq_en | input | 1 | Interrupt enable |
| over_flag | output | 1 | Sticky flag: a reading was above the ceiling |
| under_flag | output | 1 | Sticky flag: a reading was below the floor |
| irq | output | 1 | Interrupt request |

## Verification
A wrong limit word is visible on `lim_rdata` in the cycle after the write. A wrong field order or a wrong sign extension shows up only when a conversion lands near an edge, so the bench drives readings exactly at each scaled edge and one count beyond it. A flag that sets wrongly or clears wrongly is visible in the cycle after the conversion or the clear. Once it has gone wrong it stays wrong until the next clear, which lets the per-cycle comparison against the model catch it at once.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef enum logic {
    EDGE_CEIL  = 1'b0,
    EDGE_FLOOR = 1'b1
  } edge_kind_e;

  typedef struct packed {
    logic over;
    logic under;
  } swm_flags_t;

endpackage

// File: rtl/swm_limit_reg.sv
module swm_limit_reg #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    word_d = word_q;
    if (we) word_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= RST_VAL;
    else if (we) word_q <= word_d;
  end

  assign q = word_q;

endmodule

// File: rtl/swm_edge_cmp.sv
module swm_edge_cmp
  import swm_pkg::*;
#(
  parameter int unsigned READ_W = 16,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned SCALE  = 8,
  parameter edge_kind_e  KIND   = EDGE_CEIL
) (
  input  logic [READ_W-1:0] reading,
  input  logic [LIM_W-1:0]  limit,
  output logic              crossed
);

  localparam int unsigned LIM_SC_W = LIM_W + SCALE;
  localparam int unsigned CMP_W    = ((READ_W > LIM_SC_W) ? READ_W : LIM_SC_W) + 1;

  logic [LIM_SC_W-1:0]     limit_sc;
  logic signed [CMP_W-1:0] reading_x;
  logic signed [CMP_W-1:0] limit_x;

  assign limit_sc  = {limit, {SCALE{1'b0}}};
  assign reading_x = CMP_W'($signed(reading));
  assign limit_x   = CMP_W'($signed(limit_sc));

  generate
    if (KIND == EDGE_CEIL) begin : g_ceil
      assign crossed = (reading_x > limit_x);
    end else begin : g_floor
      assign crossed = (reading_x < limit_x);
    end
  endgenerate

endmodule

// File: rtl/swm_flag_ctl.sv
module swm_flag_ctl
  import swm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_done,
  input  logic       hit_over,
  input  logic       hit_under,
  input  logic       clr,
  output swm_flags_t flags
);

  swm_flags_t flags_d;
  swm_flags_t flags_q;
  logic       upd_en;

  assign upd_en = conv_done | clr;

  always_comb begin
    flags_d = flags_q;
    if (clr) flags_d = '0;
    if (conv_done) begin
      if (hit_over)  flags_d.over  = 1'b1;
      if (hit_under) flags_d.under = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/shunt_window_mon.sv
module shunt_window_mon
  import swm_pkg::*;
#(
  parameter int unsigned READ_W = 16,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned SCALE  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_done,
  input  logic [READ_W-1:0]   shunt_code,
  input  logic                lim_we,
  input  logic [2*LIM_W-1:0]  lim_wdata,
  output logic [2*LIM_W-1:0]  lim_rdata,
  input  logic                flag_clr,
  input  logic                irq_en,
  output logic                over_flag,
  output logic                under_flag,
  output logic                irq
);

  localparam int unsigned WORD_W = 2 * LIM_W;
  localparam logic [LIM_W-1:0]  CEIL_RST  = {1'b0, {(LIM_W-1){1'b1}}};
  localparam logic [LIM_W-1:0]  FLOOR_RST = {1'b1, {(LIM_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] WORD_RST  = {CEIL_RST, FLOOR_RST};

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [WORD_W-1:0] lim_word;
  logic              hit_over;
  logic              hit_under;
  swm_flags_t        flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  swm_limit_reg #(
    .WORD_W (WORD_W),
    .RST_VAL(WORD_RST)
  ) u_limits (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (lim_we),
    .wdata(lim_wdata),
    .q    (lim_word)
  );

  swm_edge_cmp #(
    .READ_W(READ_W),
    .LIM_W (LIM_W),
    .SCALE (SCALE),
    .KIND  (EDGE_CEIL)
  ) u_ceil (
    .reading(shunt_code),
    .limit  (lim_word[WORD_W-1:LIM_W]),
    .crossed(hit_over)
  );

  swm_edge_cmp #(
    .READ_W(READ_W),
    .LIM_W (LIM_W),
    .SCALE (SCALE),
    .KIND  (EDGE_FLOOR)
  ) u_floor (
    .reading(shunt_code),
    .limit  (lim_word[LIM_W-1:0]),
    .crossed(hit_under)
  );

  swm_flag_ctl u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .conv_done(conv_done),
    .hit_over (hit_over),
    .hit_under(hit_under),
    .clr      (flag_clr),
    .flags    (flags)
  );

  assign lim_rdata  = lim_word;
  assign over_flag  = flags.over;
  assign under_flag = flags.under;
  assign irq        = irq_en & (flags.over | flags.under);

endmodule

// File: rtl/swm_checker.sv
module swm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        conv_done,
  input logic [15:0] shunt_code,
  input logic        lim_we,
  input logic [15:0] lim_wdata,
  input logic [15:0] lim_rdata,
  input logic        flag_clr,
  input logic        irq_en,
  input logic        over_flag,
  input logic        under_flag,
  input logic        irq
);

  int ceil_i;
  int floor_i;
  int read_i;

  always_comb begin
    ceil_i  = int'($signed(lim_rdata[15:8])) * 256;
    floor_i = int'($signed(lim_rdata[7:0])) * 256;
    read_i  = int'($signed(shunt_code));
  end

  assert_limit_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |=> (lim_rdata == $past(lim_wdata)));

  assert_limit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lim_we |=> $stable(lim_rdata));

  assert_over_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (read_i > ceil_i)) |=> over_flag);

  assert_under_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (read_i < floor_i)) |=> under_flag);

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !flag_clr) |=> ($stable(over_flag) && $stable(under_flag)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !conv_done) |=> (!over_flag && !under_flag));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

bind shunt_window_mon swm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .conv_done (conv_done),
  .shunt_code(shunt_code),
  .lim_we    (lim_we),
  .lim_wdata (lim_wdata),
  .lim_rdata (lim_rdata),
  .flag_clr  (flag_clr),
  .irq_en    (irq_en),
  .over_flag (over_flag),
  .under_flag(under_flag),
  .irq       (irq)
);

// File: tb/sim_shunt_window_mon.sv
`timescale 1ns/1ps
module sim_shunt_window_mon;

  logic        clk;
  logic        rst_n;
  logic        conv_done;
  logic [15:0] shunt_code;
  logic        lim_we;
  logic [15:0] lim_wdata;
  logic [15:0] lim_rdata;
  logic        flag_clr;
  logic        irq_en;
  logic        over_flag;
  logic        under_flag;
  logic        irq;

  int    n_checks;
  int    n_fail;
  string tag;
  bit    done;

  logic [15:0] m_word;
  bit          m_over;
  bit          m_under;

  shunt_window_mon u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .shunt_code(shunt_code),
    .lim_we    (lim_we),
    .lim_wdata (lim_wdata),
    .lim_rdata (lim_rdata),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .over_flag (over_flag),
    .under_flag(under_flag),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference model: state updated on every rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word  = 16'h7F80;
      m_over  = 0;
      m_under = 0;
    end else begin
      int up, lo, rd;
      up = $signed(m_word[15:8]) * 256;
      lo = $signed(m_word[7:0]) * 256;
      rd = $signed(shunt_code);
      if (flag_clr) begin
        m_over  = 0;
        m_under = 0;
      end
      if (conv_done && rd > up) m_over  = 1;
      if (conv_done && rd < lo) m_under = 1;
      if (lim_we) m_word = lim_wdata;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare every output on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      check("lim_rdata", int'(lim_rdata), int'(m_word));
      check("over_flag", int'(over_flag), int'(m_over));
      check("under_flag", int'(under_flag), int'(m_under));
      check("irq", int'(irq), int'(irq_en & (m_over | m_under)));
    end
  end

  task automatic cyc(input string t, input bit cv, input int rd, input bit we,
                     input logic [15:0] wd, input bit clr, input bit en);
    @(negedge clk);
    #0.5;
    tag        = t;
    conv_done  = cv;
    shunt_code = 16'(rd);
    lim_we     = we;
    lim_wdata  = wd;
    flag_clr   = clr;
    irq_en     = en;
  endtask

  task automatic idle(input string t, input bit en);
    cyc(t, 0, 0, 0, 16'h0000, 0, en);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0; tag = "R1";
    conv_done = 0; shunt_code = '0; lim_we = 0; lim_wdata = '0;
    flag_clr = 0; irq_en = 1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) idle("R1", 1);

    // R1/R5: default window; the floor at -128 cannot trip, the ceiling is strict
    cyc("R5", 1, -32768, 0, 16'h0, 0, 1);
    idle("R5", 1);
    cyc("R4", 1, 32512, 0, 16'h0, 0, 1);
    idle("R4", 1);
    cyc("R4", 1, 32513, 0, 16'h0, 0, 1);
    idle("R4", 1);
    cyc("R7", 0, 0, 0, 16'h0, 1, 1);
    idle("R7", 1);

    // R2/R3: ceiling +10 -> 2560, floor -10 -> -2560
    cyc("R2", 0, 0, 1, 16'h0AF6, 0, 1);
    idle("R2", 1);
    cyc("R4", 1, 2560, 0, 16'h0, 0, 1);
    idle("R4", 1);
    cyc("R3", 1, 2561, 0, 16'h0, 0, 1);
    idle("R3", 1);
    cyc("R7", 1, 0, 0, 16'h0, 0, 1);
    idle("R7", 1);
    cyc("R7", 0, 0, 0, 16'h0, 1, 1);
    idle("R7", 1);
    cyc("R5", 1, -2560, 0, 16'h0, 0, 1);
    idle("R5", 1);
    cyc("R5", 1, -2561, 0, 16'h0, 0, 1);
    idle("R5", 1);
    idle("R9", 0);
    idle("R9", 1);
    cyc("R7", 0, 0, 0, 16'h0, 1, 0);
    idle("R7", 0);

    // R6: out-of-window readings without the strobe are ignored
    cyc("R6", 0, 30000, 0, 16'h0, 0, 1);
    cyc("R6", 0, -30000, 0, 16'h0, 0, 1);
    idle("R6", 1);

    // R8: crossing in the same cycle as a clear wins
    cyc("R4", 1, -20000, 0, 16'h0, 0, 1);
    cyc("R8", 1, 3000, 0, 16'h0, 1, 1);
    idle("R8", 1);

    // R3: asymmetric limits, ceiling -2 -> -512, floor -5 -> -1280
    cyc("R3", 0, 0, 1, 16'hFEFB, 1, 1);
    idle("R3", 1);
    cyc("R3", 1, -511, 0, 16'h0, 0, 1);
    idle("R3", 1);
    cyc("R3", 0, 0, 0, 16'h0, 1, 1);
    cyc("R3", 1, -1281, 0, 16'h0, 0, 1);
    idle("R3", 1);
    cyc("R3", 0, 0, 0, 16'h0, 1, 1);

    // R10: conversion during a write uses the old limits
    cyc("R2", 0, 0, 1, 16'h0AF6, 0, 1);
    cyc("R10", 1, 5000, 1, 16'h7F80, 0, 1);
    idle("R10", 1);
    cyc("R10", 0, 0, 0, 16'h0, 1, 1);
    cyc("R10", 1, 5000, 0, 16'h0, 0, 1);
    idle("R10", 1);
    idle("R10", 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule